// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block holds the operating mode of a small controller and decides, each clock, whether that mode changes. A one-cycle strobe from the CPU's sleep instruction, sampled while the system runs at medium speed, moves it into sleep, standby or watch mode. Which of the three it picks depends on a standby-select bit, a low-speed bit in the first control register and a watch-select bit in the timer block. Once the system is in one of those low-power modes, a pending interrupt brings it back to medium speed. Only certain sources may do this, and the allowed set depends on the low-power mode. The wake also needs the global interrupt mask to be clear and the low-speed bits to be set in one particular way.

The block also drives a clock-division ratio for the medium-speed clock. The ratio comes from a 2-bit field in the first control register. Both outputs are registered. The reset input models the chip's reset pin. It is active high and synchronous, and it wins over every other event. The CPU, the oscillators, the timers and the direct paths into high-speed and subactive operation are outside this block. Their mode codes exist, but this block never enters them.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `rst` is 1 at a rising edge, `mode` becomes RESET and `div_ratio` becomes 16 after that edge. Mode codes: RESET=0, HIGH=1, MEDIUM=2, SLEEP=3, STANDBY=4, WATCH=5, SUBACTIVE=6.
- R2: In RESET with `rst` at 0, the next edge moves `mode` to MEDIUM.
- R3: In MEDIUM, `sleep_stb`=1 with `stby_sel`=1, `lowspd_r1`=0 and `watch_sel`=0 moves `mode` to STANDBY at the next edge.
- R4: In MEDIUM, `sleep_stb`=1 with `stby_sel`=1 and `watch_sel`=1 moves `mode` to WATCH, whatever the value of `lowspd_r1`.
- R5: In MEDIUM, `sleep_stb`=1 with `stby_sel`=0 and `lowspd_r1`=0 moves `mode` to SLEEP.
- R6: A strobe in MEDIUM with any other bit combination leaves `mode` unchanged. A strobe in SLEEP, STANDBY or WATCH is ignored.
- R7: A low-power mode is left only for MEDIUM. The exit happens only when `lowspd_r2`=1, `lowspd_r1`=0, `irq_mask`=0 and at least one allowed source has both its request bit and its enable bit at 1.
- R8: In SLEEP, every source may wake the system: both IRQs, all eight wakeup pins and all three timers.
- R9: In STANDBY, only IRQ0, IRQ1 and wakeup pins 0 to 7 may wake the system. Timer requests are ignored.
- R10: In WATCH, only the timers, IRQ0 and wakeup pins 0 to 7 may wake the system. IRQ1 is ignored. Timer bit order: bit 0 timer A, bit 1 timer F, bit 2 timer G.
- R11: Outside HIGH, `div_ratio` equals 16 shifted left by the `med_div_sel` value sampled at the previous edge: 00→16, 01→32, 10→64, 11→128. In HIGH it is 1.
- R12: `rst` wins over a wake request or a sleep strobe that arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Reset pin asserted, synchronous, active high |
| sleep_stb | input | 1 | One-cycle strobe from the sleep instruction |
| stby_sel | input | 1 | Standby select bit |
| lowspd_r1 | input | 1 | Low-speed bit, control register 1 |
| lowspd_r2 | input | 1 | Low-speed bit, control register 2 |
| watch_sel | input | 1 | Timer watch-select bit |
| irq_mask | input | 1 | Global interrupt mask |
| irq_req | input | 2 | External IRQ requests, bit n is IRQn |
| irq_en | input | 2 | External IRQ enables |
| wkp_req | input | 8 | Wakeup pin requests |
| wkp_en | input | 8 | Wakeup pin enables |
| tmr_req | input | 3 | Timer requests (A, F, G) |
| tmr_en | input | 3 | Timer enables |
| med_div_sel | input | 2 | Medium-speed division field |
| mode | output | 3 | Current mode code |
| div_ratio | output | 8 | Clock-division ratio |

## Verification
Two events can land in the same cycle: a reset and a wake request, or a reset and a sleep strobe. The bench raises `rst` in the same cycle as an enabled, unmasked wake source while the system sleeps. In a later cycle it raises `rst` together with a sleep strobe in MEDIUM. RESET must win both times. A behavioural model compares `mode` and `div_ratio` on every clock, so the mode after the cycle that follows each collision is also judged.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int MODE_W = 3;
  typedef enum logic [MODE_W-1:0] {
    M_RESET  = 3'd0,
    M_HIGH   = 3'd1,
    M_MED    = 3'd2,
    M_SLEEP  = 3'd3,
    M_STBY   = 3'd4,
    M_WATCH  = 3'd5,
    M_SUBACT = 3'd6
  } mode_e;
endpackage

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
  parameter int N_IRQ = 2,
  parameter int N_WKP = 8,
  parameter int N_TMR = 3
) (
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic [N_WKP-1:0] wkp_req,
  input  logic [N_WKP-1:0] wkp_en,
  input  logic [N_TMR-1:0] tmr_req,
  input  logic [N_TMR-1:0] tmr_en,
  output logic             wake_sleep,
  output logic             wake_stby,
  output logic             wake_watch
);
  localparam int N_ALL = N_IRQ + N_WKP + N_TMR;
  logic [N_ALL-1:0] live;

  // each source counts only when requested and enabled
  genvar g;
  generate
    for (g = 0; g < N_IRQ; g++) begin : g_irq
      assign live[g] = irq_req[g] & irq_en[g];
    end
    for (g = 0; g < N_WKP; g++) begin : g_wkp
      assign live[N_IRQ+g] = wkp_req[g] & wkp_en[g];
    end
    for (g = 0; g < N_TMR; g++) begin : g_tmr
      assign live[N_IRQ+N_WKP+g] = tmr_req[g] & tmr_en[g];
    end
  endgenerate

  logic any_irq, any_wkp, any_tmr;
  assign any_irq    = |live[N_IRQ-1:0];
  assign any_wkp    = |live[N_IRQ+N_WKP-1:N_IRQ];
  assign any_tmr    = |live[N_ALL-1:N_IRQ+N_WKP];
  assign wake_sleep = any_irq | any_wkp | any_tmr;
  assign wake_stby  = any_irq | any_wkp;
  assign wake_watch = live[0] | any_wkp | any_tmr;
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sleep_stb,
  input  logic  stby_sel,
  input  logic  lowspd_r1,
  input  logic  lowspd_r2,
  input  logic  watch_sel,
  input  logic  irq_mask,
  input  logic  wake_sleep,
  input  logic  wake_stby,
  input  logic  wake_watch,
  output mode_e mode_q,
  output mode_e mode_d
);
  logic wake_ok;
  assign wake_ok = lowspd_r2 & ~lowspd_r1 & ~irq_mask;

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      M_RESET: mode_d = M_MED;
      M_MED: begin
        if (sleep_stb) begin
          if (stby_sel && watch_sel)            mode_d = M_WATCH;
          else if (stby_sel && !lowspd_r1)      mode_d = M_STBY;
          else if (!stby_sel && !lowspd_r1)     mode_d = M_SLEEP;
        end
      end
      M_SLEEP: if (wake_ok && wake_sleep) mode_d = M_MED;
      M_STBY:  if (wake_ok && wake_stby)  mode_d = M_MED;
      M_WATCH: if (wake_ok && wake_watch) mode_d = M_MED;
      default: mode_d = mode_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= M_RESET;
    else     mode_q <= mode_d;
  end
endmodule

// File: rtl/lpm_div_sel.sv
module lpm_div_sel
  import pwr_mode_pkg::*;
#(
  parameter int MSEL_W    = 2,
  parameter int BASE_LOG2 = 4,
  parameter int DIV_W     = BASE_LOG2 + (1 << MSEL_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  mode_e             mode_d,
  input  logic [MSEL_W-1:0] msel,
  output logic [DIV_W-1:0]  div_q
);
  localparam logic [DIV_W-1:0] ONE  = DIV_W'(1);
  localparam logic [DIV_W-1:0] BASE = ONE << BASE_LOG2;

  always_ff @(posedge clk) begin
    if (rst)                  div_q <= BASE;
    else if (mode_d == M_HIGH) div_q <= ONE;
    else                      div_q <= BASE << msel;
  end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int N_IRQ     = 2,
  parameter int N_WKP     = 8,
  parameter int N_TMR     = 3,
  parameter int MSEL_W    = 2,
  parameter int BASE_LOG2 = 4,
  parameter int DIV_W     = BASE_LOG2 + (1 << MSEL_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_stb,
  input  logic              stby_sel,
  input  logic              lowspd_r1,
  input  logic              lowspd_r2,
  input  logic              watch_sel,
  input  logic              irq_mask,
  input  logic [N_IRQ-1:0]  irq_req,
  input  logic [N_IRQ-1:0]  irq_en,
  input  logic [N_WKP-1:0]  wkp_req,
  input  logic [N_WKP-1:0]  wkp_en,
  input  logic [N_TMR-1:0]  tmr_req,
  input  logic [N_TMR-1:0]  tmr_en,
  input  logic [MSEL_W-1:0] med_div_sel,
  output logic [MODE_W-1:0] mode,
  output logic [DIV_W-1:0]  div_ratio
);
  logic  wk_sleep, wk_stby, wk_watch;
  mode_e mode_q, mode_d;

  lpm_wake_qual #(.N_IRQ(N_IRQ), .N_WKP(N_WKP), .N_TMR(N_TMR)) u_wake (
    .irq_req(irq_req), .irq_en(irq_en),
    .wkp_req(wkp_req), .wkp_en(wkp_en),
    .tmr_req(tmr_req), .tmr_en(tmr_en),
    .wake_sleep(wk_sleep), .wake_stby(wk_stby), .wake_watch(wk_watch)
  );

  lpm_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .sleep_stb(sleep_stb), .stby_sel(stby_sel),
    .lowspd_r1(lowspd_r1), .lowspd_r2(lowspd_r2), .watch_sel(watch_sel),
    .irq_mask(irq_mask), .wake_sleep(wk_sleep), .wake_stby(wk_stby),
    .wake_watch(wk_watch), .mode_q(mode_q), .mode_d(mode_d)
  );

  lpm_div_sel #(.MSEL_W(MSEL_W), .BASE_LOG2(BASE_LOG2), .DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .mode_d(mode_d), .msel(med_div_sel), .div_q(div_ratio)
  );

  assign mode = mode_q;
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk #(
  parameter int N_IRQ     = 2,
  parameter int N_WKP     = 8,
  parameter int N_TMR     = 3,
  parameter int MSEL_W    = 2,
  parameter int BASE_LOG2 = 4,
  parameter int DIV_W     = BASE_LOG2 + (1 << MSEL_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              sleep_stb,
  input logic              stby_sel,
  input logic              lowspd_r1,
  input logic              lowspd_r2,
  input logic              watch_sel,
  input logic              irq_mask,
  input logic [N_IRQ-1:0]  irq_req,
  input logic [N_IRQ-1:0]  irq_en,
  input logic [N_WKP-1:0]  wkp_req,
  input logic [N_WKP-1:0]  wkp_en,
  input logic [N_TMR-1:0]  tmr_req,
  input logic [N_TMR-1:0]  tmr_en,
  input logic [MSEL_W-1:0] med_div_sel,
  input logic [2:0]        mode,
  input logic [DIV_W-1:0]  div_ratio
);
  logic seen_rst = 1'b0;
  always_ff @(posedge clk) seen_rst <= rst;

  // R1 and R12: the edge after a sampled reset shows RESET and the base ratio
  always_ff @(negedge clk) begin
    if (seen_rst) begin
      assert_reset_state_R1: assert (mode == 3'd0 && div_ratio == DIV_W'(1 << BASE_LOG2))
        else $error("reset state wrong");
    end
  end

  logic low_pwr, no_stby_src, no_watch_src;
  assign low_pwr      = (mode == 3'd3) || (mode == 3'd4) || (mode == 3'd5);
  assign no_stby_src  = ~|(irq_req & irq_en) && ~|(wkp_req & wkp_en);
  assign no_watch_src = !(irq_req[0] && irq_en[0]) && ~|(wkp_req & wkp_en)
                        && ~|(tmr_req & tmr_en);

  assert_leave_reset_R2: assert property (@(posedge clk) disable iff (rst)
    mode == 3'd0 |=> mode == 3'd2);
  assert_to_standby_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd2 && sleep_stb && stby_sel && !lowspd_r1 && !watch_sel) |=> mode == 3'd4);
  assert_to_watch_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd2 && sleep_stb && stby_sel && watch_sel) |=> mode == 3'd5);
  assert_to_sleep_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd2 && sleep_stb && !stby_sel && !lowspd_r1) |=> mode == 3'd3);
  assert_med_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd2 && !sleep_stb) |=> mode == 3'd2);
  assert_exit_medium_only_R7: assert property (@(posedge clk) disable iff (rst)
    low_pwr |=> (mode == $past(mode) || mode == 3'd2));
  assert_wake_gated_R7: assert property (@(posedge clk) disable iff (rst)
    (low_pwr && (irq_mask || !lowspd_r2 || lowspd_r1)) |=> $stable(mode));
  assert_stby_sources_R9: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd4 && no_stby_src) |=> mode == 3'd4);
  assert_watch_sources_R10: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd5 && no_watch_src) |=> mode == 3'd5);
  assert_div_ratio_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mode == 3'd1) ? (div_ratio == DIV_W'(1))
             : (div_ratio == (DIV_W'(1 << BASE_LOG2) << $past(med_div_sel))));
endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(
  .N_IRQ(N_IRQ), .N_WKP(N_WKP), .N_TMR(N_TMR),
  .MSEL_W(MSEL_W), .BASE_LOG2(BASE_LOG2), .DIV_W(DIV_W)
) u_chk (
  .clk(clk), .rst(rst), .sleep_stb(sleep_stb), .stby_sel(stby_sel),
  .lowspd_r1(lowspd_r1), .lowspd_r2(lowspd_r2), .watch_sel(watch_sel),
  .irq_mask(irq_mask), .irq_req(irq_req), .irq_en(irq_en),
  .wkp_req(wkp_req), .wkp_en(wkp_en), .tmr_req(tmr_req), .tmr_en(tmr_en),
  .med_div_sel(med_div_sel), .mode(mode), .div_ratio(div_ratio)
);

// File: tb/test_pwr_mode_seq.sv
`timescale 1ns/1ps
module test_pwr_mode_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sleep_stb = 0, stby_sel = 0, lowspd_r1 = 0, lowspd_r2 = 0;
  logic       watch_sel = 0, irq_mask = 0;
  logic [1:0] irq_req = 0, irq_en = 0;
  logic [7:0] wkp_req = 0, wkp_en = 0;
  logic [2:0] tmr_req = 0, tmr_en = 0;
  logic [1:0] med_div_sel = 2'b11;
  logic [2:0] mode;
  logic [7:0] div_ratio;

  always #5 clk = ~clk;

  pwr_mode_seq i_pwr_mode_seq (
    .clk(clk), .rst(rst), .sleep_stb(sleep_stb), .stby_sel(stby_sel),
    .lowspd_r1(lowspd_r1), .lowspd_r2(lowspd_r2), .watch_sel(watch_sel),
    .irq_mask(irq_mask), .irq_req(irq_req), .irq_en(irq_en),
    .wkp_req(wkp_req), .wkp_en(wkp_en), .tmr_req(tmr_req), .tmr_en(tmr_en),
    .med_div_sel(med_div_sel), .mode(mode), .div_ratio(div_ratio)
  );

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  string phase = "R1";

  // behavioural reference, updated at each rising edge
  int  ref_mode = 0, ref_div = 16;
  bit  ref_valid = 0;
  always @(posedge clk) begin
    bit any_i, any_w, any_t, ok;
    any_i = (irq_req & irq_en) != 0;
    any_w = (wkp_req & wkp_en) != 0;
    any_t = (tmr_req & tmr_en) != 0;
    ok = lowspd_r2 && !lowspd_r1 && !irq_mask;
    if (rst) ref_mode = 0;
    else if (ref_mode == 0) ref_mode = 2;
    else if (ref_mode == 2) begin
      if (sleep_stb) begin
        if (stby_sel && watch_sel) ref_mode = 5;
        else if (stby_sel && !lowspd_r1) ref_mode = 4;
        else if (!stby_sel && !lowspd_r1) ref_mode = 3;
      end
    end
    else if (ref_mode == 3 && ok && (any_i || any_w || any_t)) ref_mode = 2;
    else if (ref_mode == 4 && ok && (any_i || any_w)) ref_mode = 2;
    else if (ref_mode == 5 && ok && ((irq_req[0] && irq_en[0]) || any_w || any_t)) ref_mode = 2;
    if (rst) ref_div = 16;
    else ref_div = (ref_mode == 1) ? 1 : (16 << med_div_sel);
    ref_valid = 1;
  end

  always @(negedge clk) begin
    if (ref_valid && !finished) begin
      vectors++;
      if (mode !== ref_mode[2:0] || div_ratio !== ref_div[7:0]) begin
        miscompares++;
        $display("FAIL %s per-cycle: mode=%0d div=%0d expected mode=%0d div=%0d",
                 phase, mode, div_ratio, ref_mode, ref_div);
      end
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_src();
    irq_req = 0; irq_en = 0; wkp_req = 0; wkp_en = 0; tmr_req = 0; tmr_en = 0;
  endtask

  task automatic strobe();
    sleep_stb = 1; cyc(); sleep_stb = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    phase = "R1"; check("R1 mode", mode, 0); check("R1 div", div_ratio, 16);
    rst = 0; cyc();
    phase = "R2"; check("R2", mode, 2);
    phase = "R11"; check("R11 sel11", div_ratio, 128);
    med_div_sel = 2'b00; cyc(); check("R11 sel00", div_ratio, 16);
    med_div_sel = 2'b01; cyc(); check("R11 sel01", div_ratio, 32);
    med_div_sel = 2'b10; cyc(); check("R11 sel10", div_ratio, 64);

    phase = "R6";
    stby_sel = 1; lowspd_r1 = 1; watch_sel = 0; strobe(); check("R6 stby+ls1", mode, 2);
    stby_sel = 0; lowspd_r1 = 1; strobe(); check("R6 ls1 only", mode, 2);

    phase = "R5";
    lowspd_r1 = 0; strobe(); check("R5", mode, 3);
    phase = "R7";
    tmr_req[2] = 1; tmr_en[2] = 1; lowspd_r2 = 0; cyc(); check("R7 ls2=0", mode, 3);
    lowspd_r2 = 1; irq_mask = 1; cyc(); check("R7 mask", mode, 3);
    irq_mask = 0; lowspd_r1 = 1; cyc(); check("R7 ls1=1", mode, 3);
    lowspd_r1 = 0; tmr_en[2] = 0; cyc(); check("R7 disabled", mode, 3);
    phase = "R6"; strobe(); check("R6 strobe in sleep", mode, 3);
    phase = "R8"; tmr_en[2] = 1; cyc(); check("R8 timer G", mode, 2);
    clear_src();

    phase = "R3";
    stby_sel = 1; watch_sel = 0; strobe(); check("R3", mode, 4);
    phase = "R9"; tmr_req = 3'b111; tmr_en = 3'b111; cyc(); check("R9 timers ignored", mode, 4);
    phase = "R6"; strobe(); check("R6 strobe in standby", mode, 4);
    clear_src();
    phase = "R9"; irq_req[1] = 1; irq_en[1] = 1; cyc(); check("R9 irq1", mode, 2);
    clear_src();
    strobe(); check("R3 again", mode, 4);
    wkp_req[5] = 1; wkp_en[5] = 1; cyc(); check("R9 wkp5", mode, 2);
    clear_src();

    phase = "R4";
    watch_sel = 1; lowspd_r1 = 1; strobe(); check("R4 ls1=1", mode, 5);
    lowspd_r1 = 0;
    phase = "R10"; irq_req[1] = 1; irq_en[1] = 1; cyc(); check("R10 irq1 ignored", mode, 5);
    clear_src(); tmr_req[1] = 1; tmr_en[1] = 1; cyc(); check("R10 timer F", mode, 2);
    clear_src(); strobe(); check("R4 again", mode, 5);
    irq_req[0] = 1; irq_en[0] = 1; cyc(); check("R10 irq0", mode, 2);
    clear_src();

    phase = "R8";
    stby_sel = 0; watch_sel = 0; strobe(); check("R5 again", mode, 3);
    wkp_req[0] = 1; wkp_en[0] = 1; cyc(); check("R8 wkp0", mode, 2);
    clear_src(); strobe();
    irq_req[1] = 1; irq_en[1] = 1; cyc(); check("R8 irq1", mode, 2);
    clear_src();

    phase = "R12";
    strobe(); check("R12 setup", mode, 3);
    irq_req[0] = 1; irq_en[0] = 1; rst = 1; cyc(); check("R12 rst vs wake", mode, 0);
    clear_src(); rst = 0; cyc(); check("R12 release", mode, 2);
    rst = 1; sleep_stb = 1; cyc(); sleep_stb = 0; check("R12 rst vs strobe", mode, 0);
    rst = 0; cyc(); check("R2 after R12", mode, 2);
    cyc();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule